// File: doc/BRIEF.md
# Per-Line Programmable Edge Detector

This block watches a wide bus of single-bit trace lines and flags transitions on each line separately. Each line has a 2-bit edge-type field and a 1-bit suppress bit. These are held in 32-bit configuration words that a simple valid/write register port reads and writes. On every clock the block compares the present sample of each line with the sample from the previous clock. It then raises that line's bit in a registered event vector when the transition matches the programmed type and the line is not suppressed. A single flag reports that at least one event bit is set.

The number of lines is a parameter, a multiple of 32 up to 256. Each edge-type word packs sixteen lines and each suppress word packs thirty-two lines, so the number of implemented words follows from the line count. Addresses that fall on word slots beyond that count, or that fall outside both windows, accept writes without effect and read back as zero.

Top module: `edge_det_top`

## Requirements
- R1: After reset every edge-type word and every suppress word reads zero, event_out is all zero and bus_rdata is zero.
- R2: Edge-type word n sits at byte address 0x808 + 4*n, for n below NUM_LINES/16. Line L uses bits [2*(L mod 16)+1 : 2*(L mod 16)] of word L/16, and a written word reads back unchanged.
- R3: Suppress word n sits at byte address 0x848 + 4*n, for n below NUM_LINES/32. Line L uses bit (L mod 32) of word L/32, and a written word reads back unchanged.
- R4: Edge-type code 00 flags a line only when its previous sample is 0 and its present sample is 1.
- R5: Edge-type code 01 flags a line only when its previous sample is 1 and its present sample is 0.
- R6: Edge-type code 10 flags a line on any change of its sample.
- R7: Edge-type code 11 never flags a line.
- R8: A line whose suppress bit is 1 never flags. A line whose suppress bit is 0 flags according to its code.
- R9: A line's event bit is set in the cycle after the clock edge at which the changed input is first sampled. It lasts one cycle if the input then holds. event_any is 1 exactly when some event_out bit is 1.
- R10: On leaving reset no event is reported for lines that are held steady, whatever their level.
- R11: A write to an unimplemented word slot, to an address that is not word aligned, or to any address outside both windows changes no configuration word. A read of such an address returns zero.
- R12: bus_rdata changes only in the cycle after a read strobe (bus_valid=1, bus_write=0) and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read, when bus_valid is 1 |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| lines_in | input | NUM_LINES | Monitored trace lines |
| event_out | output | NUM_LINES | Registered per-line event vector |
| event_any | output | 1 | OR of all event_out bits |

## Verification
The assertions assume that lines_in and the bus inputs are stable around the rising edge. They also assume that reset is held for at least one clock, so that the previous-sample registers are loaded from the inputs. The bench drives every input on the falling edge and asserts reset for several cycles, so both assumptions hold. Random register traffic is aimed at the region 0x800 to 0x87F, which covers both windows, the slots just beyond them and unaligned addresses. The line patterns are random and mix single-bit flips with wide changes, which keeps them within what the reference model has to predict.

// File: rtl/edge_det_pkg.sv
package edge_det_pkg;

    localparam int ADDR_W         = 12;
    localparam int DATA_W         = 32;
    localparam int CODE_W         = 2;
    localparam int LINES_PER_CTRL = DATA_W / CODE_W;
    localparam int LINES_PER_MASK = DATA_W;
    localparam int CTRL_MAX       = 16;
    localparam int MASK_MAX       = 8;
    localparam int IDX_W          = 4;

    localparam logic [ADDR_W-1:0] CTRL_BASE = 12'h808;
    localparam logic [ADDR_W-1:0] MASK_BASE = 12'h848;

    typedef enum logic [CODE_W-1:0] {
        EDGE_RISE = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_BOTH = 2'b10,
        EDGE_RSVD = 2'b11
    } edge_mode_e;

    typedef struct packed {
        logic              ctrl_hit;
        logic              mask_hit;
        logic [IDX_W-1:0]  idx;
    } addr_dec_t;

    function automatic logic edge_match(edge_mode_e mode, logic prev, logic cur);
        logic hit;
        case (mode)
            EDGE_RISE: hit = cur & ~prev;
            EDGE_FALL: hit = prev & ~cur;
            EDGE_BOTH: hit = cur ^ prev;
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

    function automatic addr_dec_t decode_addr(logic [ADDR_W-1:0] a,
                                              logic [ADDR_W-1:0] ctrl_end,
                                              logic [ADDR_W-1:0] mask_end);
        addr_dec_t d;
        logic aligned;
        aligned    = (a[1:0] == 2'b00);
        d.ctrl_hit = aligned && (a >= CTRL_BASE) && (a < ctrl_end);
        d.mask_hit = aligned && (a >= MASK_BASE) && (a < mask_end);
        if (d.ctrl_hit)
            d.idx = IDX_W'((a - CTRL_BASE) >> 2);
        else if (d.mask_hit)
            d.idx = IDX_W'((a - MASK_BASE) >> 2);
        else
            d.idx = '0;
        return d;
    endfunction

endpackage

// File: rtl/edge_cfg_regs.sv
module edge_cfg_regs
    import edge_det_pkg::*;
#(
    parameter int NUM_LINES = 64
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bus_valid,
    input  logic                    bus_write,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       bus_rdata,
    output logic [CODE_W*NUM_LINES-1:0] ctrl_flat,
    output logic [NUM_LINES-1:0]    mask_flat
);

    localparam int CTRL_WORDS = NUM_LINES / LINES_PER_CTRL;
    localparam int MASK_WORDS = NUM_LINES / LINES_PER_MASK;
    localparam logic [ADDR_W-1:0] CTRL_END = ADDR_W'(CTRL_BASE + 4 * CTRL_WORDS);
    localparam logic [ADDR_W-1:0] MASK_END = ADDR_W'(MASK_BASE + 4 * MASK_WORDS);

    logic [DATA_W-1:0] ctrl_q [CTRL_WORDS];
    logic [DATA_W-1:0] mask_q [MASK_WORDS];
    addr_dec_t         dec;
    logic              wr_en;
    logic              rd_en;
    logic [DATA_W-1:0] rd_next;

    assign dec   = decode_addr(bus_addr, CTRL_END, MASK_END);
    assign wr_en = bus_valid && bus_write;
    assign rd_en = bus_valid && !bus_write;

    for (genvar n = 0; n < CTRL_WORDS; n++) begin : g_ctrl
        always_ff @(posedge clk) begin
            if (rst)
                ctrl_q[n] <= '0;
            else if (wr_en && dec.ctrl_hit && dec.idx == IDX_W'(n))
                ctrl_q[n] <= bus_wdata;
        end
        assign ctrl_flat[n*DATA_W +: DATA_W] = ctrl_q[n];
    end

    for (genvar n = 0; n < MASK_WORDS; n++) begin : g_mask
        always_ff @(posedge clk) begin
            if (rst)
                mask_q[n] <= '0;
            else if (wr_en && dec.mask_hit && dec.idx == IDX_W'(n))
                mask_q[n] <= bus_wdata;
        end
        assign mask_flat[n*DATA_W +: DATA_W] = mask_q[n];
    end

    always_comb begin
        rd_next = '0;
        for (int n = 0; n < CTRL_WORDS; n++)
            if (dec.ctrl_hit && dec.idx == IDX_W'(n))
                rd_next = ctrl_q[n];
        for (int n = 0; n < MASK_WORDS; n++)
            if (dec.mask_hit && dec.idx == IDX_W'(n))
                rd_next = mask_q[n];
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else if (rd_en)
            bus_rdata <= rd_next;
    end

    AST_MISS_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !dec.ctrl_hit && !dec.mask_hit) |=> (bus_rdata == '0)); // R11

    AST_MISS_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !dec.ctrl_hit && !dec.mask_hit) |=> ($stable(ctrl_flat) && $stable(mask_flat))); // R11

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(bus_rdata)); // R12

endmodule

// File: rtl/edge_line_cell.sv
module edge_line_cell
    import edge_det_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       line_i,
    input  edge_mode_e mode_i,
    input  logic       mask_i,
    output logic       ev_o
);

    logic prev_q;
    logic ev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= line_i;
            ev_q   <= 1'b0;
        end else begin
            prev_q <= line_i;
            ev_q   <= !mask_i && edge_match(mode_i, prev_q, line_i);
        end
    end

    assign ev_o = ev_q;

    AST_RSVD_SILENT: assert property (@(posedge clk) disable iff (rst)
        (mode_i == EDGE_RSVD) |=> !ev_o); // R7

    AST_MASK_SILENT: assert property (@(posedge clk) disable iff (rst)
        mask_i |=> !ev_o); // R8

    AST_STEADY_SILENT: assert property (@(posedge clk) disable iff (rst)
        (line_i == prev_q) |=> !ev_o); // R9

    AST_RISE_ONLY: assert property (@(posedge clk) disable iff (rst)
        ((mode_i == EDGE_RISE) && !line_i) |=> !ev_o); // R4

    AST_FALL_ONLY: assert property (@(posedge clk) disable iff (rst)
        ((mode_i == EDGE_FALL) && line_i) |=> !ev_o); // R5

endmodule

// File: rtl/edge_det_top.sv
module edge_det_top
    import edge_det_pkg::*;
#(
    parameter int NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [11:0]          bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_LINES-1:0] lines_in,
    output logic [NUM_LINES-1:0] event_out,
    output logic                 event_any
);

    logic [CODE_W*NUM_LINES-1:0] ctrl_flat;
    logic [NUM_LINES-1:0]        mask_flat;

    edge_cfg_regs #(
        .NUM_LINES (NUM_LINES)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ctrl_flat (ctrl_flat),
        .mask_flat (mask_flat)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        edge_line_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .line_i (lines_in[i]),
            .mode_i (edge_mode_e'(ctrl_flat[i*CODE_W +: CODE_W])),
            .mask_i (mask_flat[i]),
            .ev_o   (event_out[i])
        );
    end

    assign event_any = |event_out;

    AST_START_QUIET: assert property (@(posedge clk)
        ($past(rst) && !rst && $stable(lines_in)) |=> (event_out == '0)); // R10

endmodule

// File: tb/tb_edge_det_top.sv
`timescale 1ns/1ps
module tb_edge_det_top;

    localparam int NL = 64;
    localparam int CW = NL / 16;
    localparam int MW = NL / 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NL-1:0] lines_in = '0;
    logic [NL-1:0] event_out;
    logic          event_any;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit cmp_en = 0;

    always #2.5 clk = ~clk;

    edge_det_top #(.NUM_LINES(NL)) dut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .lines_in(lines_in), .event_out(event_out), .event_any(event_any)
    );

    // Behavioural reference model
    logic [31:0]   m_cw [16];
    logic [31:0]   m_mw [8];
    logic [NL-1:0] m_prev;
    logic [NL-1:0] m_ev;
    logic [31:0]   m_rd;

    function automatic int slot(logic [11:0] a, int base, int count);
        int ai = int'(a);
        if (a[1:0] != 2'b00) return -1;
        if (ai < base || ai >= base + 4 * count) return -1;
        return (ai - base) / 4;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < 16; k++) m_cw[k] = '0;
            for (int k = 0; k < 8; k++)  m_mw[k] = '0;
            m_prev = lines_in;
            m_ev   = '0;
            m_rd   = '0;
        end else begin
            for (int l = 0; l < NL; l++) begin
                int  code;
                bit  p, c, h;
                code = int'(m_cw[l / 16][(l % 16) * 2 +: 2]);
                p = m_prev[l];
                c = lines_in[l];
                h = (code == 0 && c && !p) || (code == 1 && !c && p) || (code == 2 && c != p);
                m_ev[l] = h && !m_mw[l / 32][l % 32];
            end
            m_prev = lines_in;
            if (bus_valid) begin
                int cs, ms;
                cs = slot(bus_addr, 'h808, CW);
                ms = slot(bus_addr, 'h848, MW);
                if (bus_write) begin
                    if (cs >= 0) m_cw[cs] = bus_wdata;
                    if (ms >= 0) m_mw[ms] = bus_wdata;
                end else begin
                    m_rd = (cs >= 0) ? m_cw[cs] : (ms >= 0) ? m_mw[ms] : 32'h0;
                end
            end
        end
    end

    task automatic check(bit ok, string tag, logic [NL-1:0] act, logic [NL-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en && !rst) begin
            check(event_out == m_ev, "R4 R5 R6 R7 R8 R9 event vector vs model", event_out, m_ev);
            check(event_any == (|m_ev), "R9 event_any vs model", NL'(event_any), NL'(|m_ev));
            check(bus_rdata == m_rd, "R12 rdata vs model", NL'(bus_rdata), NL'(m_rd));
        end
    end

    task automatic wr(logic [11:0] a, logic [31:0] d);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
        bus_valid = 1; bus_write = 0; bus_addr = a;
        @(negedge clk);
        bus_valid = 0;
        check(bus_rdata == exp, tag, NL'(bus_rdata), NL'(exp));
    endtask

    task automatic step_check(logic [NL-1:0] nxt, logic [NL-1:0] exp, string tag);
        lines_in = nxt;
        @(negedge clk);
        check(event_out == exp, tag, event_out, exp);
        check(event_any == (|exp), tag, NL'(event_any), NL'(|exp));
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [NL-1:0] v;
        repeat (4) @(negedge clk);
        rst = 0;
        cmp_en = 1;
        @(negedge clk);
        // R1: reset state
        check(event_out == '0, "R1 events after reset", event_out, '0);
        for (int n = 0; n < CW; n++) rd(12'(12'h808 + 4 * n), 32'h0, "R1 ctrl word reset");
        for (int n = 0; n < MW; n++) rd(12'(12'h848 + 4 * n), 32'h0, "R1 mask word reset");

        // R2 R3: packing; line6=01, line7=10, line8=11, line33=10, line40=10 masked
        wr(12'h808, 32'h0003_9000);
        wr(12'h810, 32'h0002_0008);
        wr(12'h84C, 32'h0000_0100);
        rd(12'h808, 32'h0003_9000, "R2 ctrl word0 readback");
        rd(12'h810, 32'h0002_0008, "R2 ctrl word2 readback");
        rd(12'h84C, 32'h0000_0100, "R3 mask word1 readback");

        // R4..R8 directed
        v = '0; v[5] = 1; v[6] = 1; v[7] = 1; v[8] = 1; v[33] = 1; v[40] = 1;
        begin
            logic [NL-1:0] e;
            e = '0; e[5] = 1; e[7] = 1; e[33] = 1;
            step_check(v, e, "R4 R6 R7 R8 rising pattern");
            step_check(v, '0, "R9 single-cycle pulse");
            e = '0; e[6] = 1; e[7] = 1; e[33] = 1;
            step_check('0, e, "R5 R6 R7 R8 falling pattern");
        end

        // R11: unimplemented slots
        wr(12'h818, 32'hFFFF_FFFF);
        wr(12'h850, 32'hFFFF_FFFF);
        wr(12'h80A, 32'hFFFF_FFFF);
        wr(12'h900, 32'hFFFF_FFFF);
        rd(12'h818, 32'h0, "R11 ctrl slot beyond count reads zero");
        rd(12'h850, 32'h0, "R11 mask slot beyond count reads zero");
        rd(12'h80A, 32'h0, "R11 unaligned reads zero");
        rd(12'h900, 32'h0, "R11 outside window reads zero");
        rd(12'h808, 32'h0003_9000, "R11 ctrl word0 untouched");
        rd(12'h848, 32'h0, "R11 mask word0 untouched");
        begin
            logic [NL-1:0] e;
            e = '0; e[0] = 1;
            step_check(e, e, "R11 line0 still rising only");
            step_check('0, '0, "R11 line0 fall ignored");
        end

        // R10: restart with lines held high
        rst = 1; lines_in = '1;
        repeat (3) @(negedge clk);
        rst = 0;
        repeat (3) begin
            @(negedge clk);
            check(event_out == '0, "R10 no start-up event", event_out, '0);
        end
        rd(12'h808, 32'h0, "R1 ctrl cleared by reset");

        // Random phase, checked against the model each cycle
        for (int c = 0; c < 3000; c++) begin
            if ($urandom_range(0, 3) == 0)
                lines_in = {$urandom, $urandom};
            else
                lines_in[$urandom_range(0, NL - 1)] ^= 1'b1;
            if ($urandom_range(0, 4) == 0) begin
                bus_valid = 1;
                bus_write = $urandom_range(0, 1) == 1;
                bus_addr  = 12'(12'h800 + $urandom_range(0, 127));
                if ($urandom_range(0, 1) == 1) bus_addr[1:0] = 2'b00;
                bus_wdata = $urandom;
            end else begin
                bus_valid = 0;
            end
            @(negedge clk);
        end
        bus_valid = 0;
        @(negedge clk);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule